// File: doc/BRIEF.md
# Configurable GPIO Port Register Block

This block is a general-purpose I/O port of up to sixteen pins, controlled through word-addressed 32-bit registers. Software gives each pin a direction (input or output), an output style (push-pull or open-drain) and a pull setting (none, up or down). Each pin also has a stored output value, which can be written whole or changed atomically through a set/clear register and a clear-only register.

Each cycle the block works out the level of every pin. It takes into account the pin's configuration, its stored output value, an optional external driver and the pull. The resolved levels are registered and can be read back as one input-data word. The same registered levels also leave the block as one level line per pin, toward a system event controller.

An external driver that fights a pin the port is driving gets disconnected. It stays ignored until it is released or changes its level. Open-drain pins are the exception: an external low always wins on them.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register reads MODE_RST, the pull register reads PULL_RST, the output-type and output-data registers read 0, and input data reads LEVEL_RST.
- R2: The register at byte offset 0x00 holds 2 direction bits per pin at bits [2p+1:2p]. Code 1 selects output, and codes 0, 2 and 3 all behave as input. Offset 0x04 holds 1 output-type bit per pin (1 = open-drain). Offset 0x0C holds 2 pull bits per pin (1 = up, 2 = down, 0 and 3 = none).
- R3: A write to output data (offset 0x14) is stored even while the pin is an input. The stored value reaches the pin once its direction becomes output.
- R4: A write to offset 0x18 sets the output-data bits selected by bits [15:0] and clears those selected by bits [31:16]. When both the set bit and the clear bit of a pin are 1, the pin ends at 1. Offset 0x18 reads as 0.
- R5: A write to offset 0x28 clears the output-data bits where bits [15:0] are 1 and leaves the other bits unchanged. Offset 0x28 reads as 0.
- R6: An input pin whose external driver is connected reads the driven level. With no driver, it reads 1 with pull-up and 0 with pull-down. With no pull, it reads its LEVEL_RST bit.
- R7: A push-pull output pin shows its output-data bit and ignores any external driver. A driver present while the pin is a push-pull output stays disconnected, also after the pin returns to input, until the driver is released or changes level.
- R8: An open-drain output pin shows its output-data bit while the external driver is absent or high, and shows 0 while the external driver is low.
- R9: Input data (offset 0x10) shows the resolved level of every pin one clock after the cause. Writes to offset 0x10 change no register.
- R10: Each pin's event line equals its bit of the input-data register, so it rises on a 0-to-1 change and falls on a 1-to-0 change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_drv_en | input | N_PINS | External driver present, per pin |
| pad_drv_lvl | input | N_PINS | Level of the external driver, per pin |
| evt_o | output | N_PINS | Resolved pin level lines toward the event controller |

## Verification
The resolution of pin levels is exercised under several patterns of external drive:
- no driver under each pull code, which separates pull-up, pull-down and the floating reset level;
- a driver on an input pin, which shows whether input follows the pad;
- a driver opposing a push-pull output, which exposes any leak of the pad into an owned pin;
- high and low drive on an open-drain output, which tells the ignored high from the winning low.

A driver held unchanged across a switch from output back to input checks that the disconnection persists, and a later toggle checks that it clears. The output-data paths are tried in three ways: a write while the pin is an input, a set/clear write with both halves selected, and a clear-only write with mixed bits. Together these separate storage from visibility and show set priority and per-bit masking.

// File: rtl/gpio_port_pkg.sv
// Shared constants and codes of the GPIO port.
// Assumes a 6-bit byte offset and at most 16 pins per port.
package gpio_port_pkg;
    localparam int ADDR_W   = 6;
    localparam int DATA_W   = 32;
    localparam int CLR_BASE = 16;   // first clear bit in the set/clear word

    localparam logic [ADDR_W-1:0] OFS_DIR  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_OTYP = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_PULL = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_IN   = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_OUT  = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_SETC = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_CLR  = 6'h28;

    typedef enum logic [1:0] {
        DIR_IN  = 2'd0,
        DIR_OUT = 2'd1,
        DIR_ALT = 2'd2,
        DIR_ANA = 2'd3
    } dir_code_e;

    typedef enum logic [1:0] {
        PULL_NONE = 2'd0,
        PULL_UP   = 2'd1,
        PULL_DOWN = 2'd2,
        PULL_RSVD = 2'd3
    } pull_code_e;
endpackage

// File: rtl/gpio_port_regs.sv
// Configuration and output-data registers of the GPIO port.
// Decodes single-cycle writes by byte offset and applies the atomic
// set/clear and clear-only updates to output data.
// Assumes N_PINS <= 16 so the clear half of the set/clear word fits.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int                  N_PINS   = 16,
    parameter logic [2*N_PINS-1:0] MODE_RST = '1,
    parameter logic [2*N_PINS-1:0] PULL_RST = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [2*N_PINS-1:0] mode_q,
    output logic [N_PINS-1:0]   otype_q,
    output logic [2*N_PINS-1:0] pull_q,
    output logic [N_PINS-1:0]   odr_q
);
    localparam int FLD2_W = 2 * N_PINS;

    logic [N_PINS-1:0] set_bits;
    logic [N_PINS-1:0] clr_bits;

    // Split the write word into per-pin set and clear masks.
    always_comb begin
        set_bits = bus_wdata[N_PINS-1:0];
        clr_bits = bus_wdata[CLR_BASE +: N_PINS];
    end

    // Configuration registers: whole-word writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_RST;
            otype_q <= '0;
            pull_q  <= PULL_RST;
        end else if (bus_wr) begin
            if (bus_addr == OFS_DIR)  mode_q  <= bus_wdata[FLD2_W-1:0];
            if (bus_addr == OFS_OTYP) otype_q <= bus_wdata[N_PINS-1:0];
            if (bus_addr == OFS_PULL) pull_q  <= bus_wdata[FLD2_W-1:0];
        end
    end

    // Output data: plain write, set-over-clear, or clear-only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odr_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_OUT:  odr_q <= bus_wdata[N_PINS-1:0];
                OFS_SETC: odr_q <= (odr_q & ~clr_bits) | set_bits;
                OFS_CLR:  odr_q <= odr_q & ~set_bits;
                default:  odr_q <= odr_q;
            endcase
        end
    end
endmodule

// File: rtl/gpio_pin_resolve.sv
// Level resolution for one pin.
// Combines direction, output type, pull, stored output and the external
// driver, and keeps a flag telling whether that driver is disconnected.
// Assumes drv_chg is high in any cycle where the driver level differs
// from the previous cycle.
module gpio_pin_resolve
    import gpio_port_pkg::*;
#(
    parameter logic FLOAT_LVL = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] dir,
    input  logic       od,
    input  logic [1:0] pull,
    input  logic       odr,
    input  logic       drv_en,
    input  logic       drv_lvl,
    input  logic       drv_chg,
    output logic       lvl
);
    logic disc_q;
    logic is_out;
    logic conn;
    logic fight;

    // A driver counts unless it was cut off and has not moved since.
    always_comb begin
        is_out = (dir == DIR_OUT);
        conn   = drv_en & (~disc_q | drv_chg);
        fight  = is_out & drv_en & (~od | drv_lvl);
    end

    // Pick the pin level from the owner of the pin.
    always_comb begin
        if (is_out) begin
            if (od) lvl = odr & ~(drv_en & ~drv_lvl);
            else    lvl = odr;
        end else if (conn) begin
            lvl = drv_lvl;
        end else if (pull == PULL_UP) begin
            lvl = 1'b1;
        end else if (pull == PULL_DOWN) begin
            lvl = 1'b0;
        end else begin
            lvl = FLOAT_LVL;
        end
    end

    // Disconnect on a fight; reconnect on release or a level change.
    always_ff @(posedge clk) begin
        if (!rst_n)                 disc_q <= 1'b0;
        else if (fight)             disc_q <= 1'b1;
        else if (!drv_en || drv_chg) disc_q <= 1'b0;
    end
endmodule

// File: rtl/gpio_port_rdmux.sv
// Read-back multiplexer of the GPIO port.
// Pure combinational; write-only and unmapped offsets read as zero.
module gpio_port_rdmux
    import gpio_port_pkg::*;
#(
    parameter int N_PINS = 16
) (
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [2*N_PINS-1:0] mode_q,
    input  logic [N_PINS-1:0]   otype_q,
    input  logic [2*N_PINS-1:0] pull_q,
    input  logic [N_PINS-1:0]   odr_q,
    input  logic [N_PINS-1:0]   lvl_q,
    output logic [DATA_W-1:0]   bus_rdata
);
    // Select the addressed register, zero-extended.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_DIR:  bus_rdata[2*N_PINS-1:0] = mode_q;
            OFS_OTYP: bus_rdata[N_PINS-1:0]   = otype_q;
            OFS_PULL: bus_rdata[2*N_PINS-1:0] = pull_q;
            OFS_IN:   bus_rdata[N_PINS-1:0]   = lvl_q;
            OFS_OUT:  bus_rdata[N_PINS-1:0]   = odr_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port.sv
// GPIO port top: register file, one resolver per pin, and registered
// pin levels that feed both the input-data register and the event lines.
// Assumes the external drive inputs are synchronous to clk.
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int                  N_PINS    = 16,
    parameter logic [2*N_PINS-1:0] MODE_RST  = '1,
    parameter logic [2*N_PINS-1:0] PULL_RST  = 32'h0000_0100,
    parameter logic [N_PINS-1:0]   LEVEL_RST = 16'h0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_PINS-1:0] pad_drv_en,
    input  logic [N_PINS-1:0] pad_drv_lvl,
    output logic [N_PINS-1:0] evt_o
);
    logic [2*N_PINS-1:0] mode_q;
    logic [N_PINS-1:0]   otype_q;
    logic [2*N_PINS-1:0] pull_q;
    logic [N_PINS-1:0]   odr_q;
    logic [N_PINS-1:0]   drv_prev_q;
    logic [N_PINS-1:0]   drv_chg;
    logic [N_PINS-1:0]   lvl_d;
    logic [N_PINS-1:0]   lvl_q;

    gpio_port_regs #(
        .N_PINS   (N_PINS),
        .MODE_RST (MODE_RST),
        .PULL_RST (PULL_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .mode_q    (mode_q),
        .otype_q   (otype_q),
        .pull_q    (pull_q),
        .odr_q     (odr_q)
    );

    // Remember last driver levels to detect a fresh drive.
    always_ff @(posedge clk) begin
        if (!rst_n) drv_prev_q <= '0;
        else        drv_prev_q <= pad_drv_lvl;
    end

    // Flag pins whose driver level moved this cycle.
    always_comb drv_chg = pad_drv_lvl ^ drv_prev_q;

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        gpio_pin_resolve #(
            .FLOAT_LVL (LEVEL_RST[i])
        ) u_res (
            .clk     (clk),
            .rst_n   (rst_n),
            .dir     (mode_q[2*i +: 2]),
            .od      (otype_q[i]),
            .pull    (pull_q[2*i +: 2]),
            .odr     (odr_q[i]),
            .drv_en  (pad_drv_en[i]),
            .drv_lvl (pad_drv_lvl[i]),
            .drv_chg (drv_chg[i]),
            .lvl     (lvl_d[i])
        );
    end

    // Register the resolved levels for readback and event lines.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= LEVEL_RST;
        else        lvl_q <= lvl_d;
    end

    // Event lines follow the registered levels.
    always_comb evt_o = lvl_q;

    gpio_port_rdmux #(
        .N_PINS (N_PINS)
    ) u_rdmux (
        .bus_addr  (bus_addr),
        .mode_q    (mode_q),
        .otype_q   (otype_q),
        .pull_q    (pull_q),
        .odr_q     (odr_q),
        .lvl_q     (lvl_q),
        .bus_rdata (bus_rdata)
    );
endmodule

// File: rtl/gpio_port_chk.sv
// Property checker for gpio_port, attached by bind below.
// Observes ports and the register-file outputs; drives nothing.
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int N_PINS = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [N_PINS-1:0]   pad_drv_en,
    input logic [N_PINS-1:0]   pad_drv_lvl,
    input logic [N_PINS-1:0]   evt_o,
    input logic [2*N_PINS-1:0] mode_q,
    input logic [N_PINS-1:0]   otype_q,
    input logic [2*N_PINS-1:0] pull_q,
    input logic [N_PINS-1:0]   odr_q
);
    logic [N_PINS-1:0] pp_mask;
    logic [N_PINS-1:0] od_low_mask;
    logic [N_PINS-1:0] pu_free_mask;

    // Per-pin condition masks used by the properties.
    always_comb begin
        for (int i = 0; i < N_PINS; i++) begin
            pp_mask[i]      = (mode_q[2*i +: 2] == DIR_OUT) && !otype_q[i];
            od_low_mask[i]  = (mode_q[2*i +: 2] == DIR_OUT) && otype_q[i]
                              && pad_drv_en[i] && !pad_drv_lvl[i];
            pu_free_mask[i] = (mode_q[2*i +: 2] != DIR_OUT)
                              && (pull_q[2*i +: 2] == PULL_UP) && !pad_drv_en[i];
        end
    end

    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_SETC) |=>
        ((odr_q & $past(bus_wdata[N_PINS-1:0])) == $past(bus_wdata[N_PINS-1:0])));

    a_r5_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CLR) |=>
        ((odr_q & $past(bus_wdata[N_PINS-1:0])) == '0));

    a_r6_pull_up_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_free_mask != '0) |=> ((evt_o & $past(pu_free_mask)) == $past(pu_free_mask)));

    a_r7_push_pull_owns: assert property (@(posedge clk) disable iff (!rst_n)
        (pp_mask != '0) |=> (((evt_o ^ $past(odr_q)) & $past(pp_mask)) == '0));

    a_r8_od_low_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (od_low_mask != '0) |=> ((evt_o & $past(od_low_mask)) == '0));

    a_r9_in_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_IN) |=>
        ($stable(mode_q) && $stable(otype_q) && $stable(pull_q) && $stable(odr_q)));

    a_r10_evt_matches_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_IN) |-> (bus_rdata[N_PINS-1:0] == evt_o));
endmodule

bind gpio_port gpio_port_chk #(.N_PINS(N_PINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pad_drv_en  (pad_drv_en),
    .pad_drv_lvl (pad_drv_lvl),
    .evt_o       (evt_o),
    .mode_q      (mode_q),
    .otype_q     (otype_q),
    .pull_q      (pull_q),
    .odr_q       (odr_q)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
// Scoreboard bench for gpio_port: driver tasks queue expected values,
// a monitor pops and compares them at the falling edge.
module sim_gpio_port;
    localparam logic [5:0] A_DIR = 6'h00, A_OTYP = 6'h04, A_PULL = 6'h0C,
                           A_IN = 6'h10, A_OUT = 6'h14, A_SETC = 6'h18, A_CLR = 6'h28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pad_drv_en = '0;
    logic [15:0] pad_drv_lvl = '0;
    logic [15:0] evt_o;

    gpio_port u0 (
        .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .pad_drv_en (pad_drv_en), .pad_drv_lvl (pad_drv_lvl), .evt_o (evt_o)
    );

    always #2 clk = ~clk;

    typedef struct {
        bit          is_evt;
        logic [31:0] exp;
        int          req;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 0;
    logic  mon_go = 1'b0;
    logic [31:0] m = 32'hFFFF_FFFF;
    logic [31:0] p = 32'h0000_0100;

    function automatic logic [31:0] set2(logic [31:0] v, int pin, logic [1:0] c);
        logic [31:0] r = v;
        r[2*pin +: 2] = c;
        return r;
    endfunction

    // Monitor: compare the observed value against the queued expectation.
    always @(negedge clk) begin
        if (mon_go && q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            act = it.is_evt ? {16'h0, evt_o} : bus_rdata;
            n_checks++;
            if (act !== it.exp) begin
                n_errors++;
                $display("FAIL R%0d: actual %h expected %h", it.req, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(posedge clk);
        bus_wr <= 1'b1; bus_addr <= a; bus_wdata <= d;
        @(posedge clk);
        bus_wr <= 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] e, input int r);
        item_t it;
        it.is_evt = 0; it.exp = e; it.req = r;
        q.push_back(it);
        @(posedge clk);
        bus_addr <= a; mon_go <= 1'b1;
        @(posedge clk);
        mon_go <= 1'b0;
    endtask

    task automatic ev(input logic [15:0] e, input int r);
        item_t it;
        it.is_evt = 1; it.exp = {16'h0, e}; it.req = r;
        q.push_back(it);
        @(posedge clk);
        mon_go <= 1'b1;
        @(posedge clk);
        mon_go <= 1'b0;
    endtask

    task automatic drive(input logic [15:0] en, input logic [15:0] lv);
        @(posedge clk);
        pad_drv_en <= en; pad_drv_lvl <= lv;
        @(posedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        rst_n <= 1'b1;
        // R1 reset state
        rd(A_DIR, 32'hFFFF_FFFF, 1);
        rd(A_PULL, 32'h0000_0100, 1);
        rd(A_OTYP, 32'h0, 1);
        rd(A_OUT, 32'h0, 1);
        rd(A_IN, 32'h0010, 1);
        ev(16'h0010, 10);   // R10 lines match reset levels
        // R3 stored while input, shown once output
        wr(A_OUT, 32'h0020);
        rd(A_IN, 32'h0010, 3);
        rd(A_OUT, 32'h0020, 3);
        m = set2(m, 5, 2'd1); wr(A_DIR, m);
        rd(A_IN, 32'h0030, 3);
        ev(16'h0030, 10);   // R10 rise
        wr(A_OUT, 32'h0);
        ev(16'h0010, 10);   // R10 fall
        // R4 set/clear with set priority
        wr(A_SETC, 32'h0000_0020);
        rd(A_OUT, 32'h0020, 4);
        rd(A_SETC, 32'h0, 4);
        wr(A_SETC, 32'h0020_0000);
        rd(A_OUT, 32'h0, 4);
        wr(A_SETC, 32'h0020_0020);
        rd(A_OUT, 32'h0020, 4);
        // R5 clear-only
        wr(A_SETC, 32'h0000_00C0);
        rd(A_OUT, 32'h00E0, 5);
        wr(A_CLR, 32'h0000_0040);
        rd(A_OUT, 32'h00A0, 5);
        rd(A_CLR, 32'h0, 5);
        rd(A_IN, 32'h0030, 5);
        // R2 code 2 behaves as input; field layout read back
        m = set2(m, 5, 2'd2); wr(A_DIR, m);
        rd(A_IN, 32'h0010, 2);
        rd(A_DIR, m, 2);
        wr(A_OUT, 32'h0);
        // R6 input resolution
        drive(16'h0100, 16'h0100);
        rd(A_IN, 32'h0110, 6);
        drive(16'h0100, 16'h0000);
        rd(A_IN, 32'h0010, 6);
        drive(16'h0000, 16'h0000);
        m = set2(m, 8, 2'd0); wr(A_DIR, m);
        p = set2(p, 8, 2'd1); wr(A_PULL, p);
        rd(A_IN, 32'h0110, 6);
        p = set2(p, 8, 2'd2); wr(A_PULL, p);
        rd(A_IN, 32'h0010, 6);
        p = set2(p, 4, 2'd0); wr(A_PULL, p);
        rd(A_IN, 32'h0010, 6);    // pin 4 floats to its reset level 1
        p = set2(p, 4, 2'd2); wr(A_PULL, p);
        rd(A_IN, 32'h0000, 6);
        p = set2(p, 4, 2'd1); wr(A_PULL, p);
        rd(A_IN, 32'h0010, 6);
        // R7 push-pull ownership and disconnect
        drive(16'h0200, 16'h0200);
        rd(A_IN, 32'h0210, 7);
        m = set2(m, 9, 2'd1); wr(A_DIR, m);
        rd(A_IN, 32'h0010, 7);
        drive(16'h0200, 16'h0000);
        wr(A_SETC, 32'h0000_0200);
        rd(A_IN, 32'h0210, 7);
        wr(A_CLR, 32'h0000_0200);
        rd(A_IN, 32'h0010, 7);
        drive(16'h0200, 16'h0200);
        p = set2(p, 9, 2'd2); wr(A_PULL, p);
        m = set2(m, 9, 2'd0); wr(A_DIR, m);
        rd(A_IN, 32'h0010, 7);    // still disconnected
        drive(16'h0200, 16'h0000);
        rd(A_IN, 32'h0010, 7);
        drive(16'h0200, 16'h0200);
        rd(A_IN, 32'h0210, 7);    // reconnected after change
        drive(16'h0000, 16'h0000);
        rd(A_IN, 32'h0010, 7);
        // R8 open-drain
        wr(A_OTYP, 32'h0400);
        rd(A_OTYP, 32'h0400, 8);
        wr(A_SETC, 32'h0000_0400);
        m = set2(m, 10, 2'd1); wr(A_DIR, m);
        rd(A_IN, 32'h0410, 8);
        drive(16'h0400, 16'h0400);
        rd(A_IN, 32'h0410, 8);
        drive(16'h0400, 16'h0000);
        rd(A_IN, 32'h0010, 8);
        drive(16'h0000, 16'h0000);
        rd(A_IN, 32'h0410, 8);
        ev(16'h0410, 10);
        wr(A_CLR, 32'h0000_0400);
        rd(A_IN, 32'h0010, 8);
        // R9 writes to input data ignored
        wr(A_IN, 32'h0000_FFFF);
        rd(A_IN, 32'h0010, 9);
        rd(A_DIR, m, 9);
        rd(A_OUT, 32'h0, 9);
        repeat (3) @(posedge clk);
        if (q.size() != 0) begin
            n_checks++; n_errors++;
            $display("FAIL R9: actual %0d pending expected 0", q.size());
        end
        finish_run();
    end
endmodule